// File: doc/BRIEF.md
# Parameter Block Command Sequencer

This block runs one disk command from start to finish. The host gives the system-memory address of a seven-byte parameter block and pulses start. The sequencer then reads the block one byte at a time through a bus-master read port. It decodes the drive, the opcode and the addressing fields, and validates the command.

A command that passes validation either completes inside the sequencer or goes to a transfer engine. Position commands and no-op style commands complete inside the sequencer. Read, write and format go to the transfer engine, and the sequencer waits for that engine to report back. Every command ends with a result type, an error byte, a set interrupt flag and a one-cycle completion pulse.

The sequencer keeps a track register and a sector register for each drive. Seek and recalibrate update them, and the host can observe them.

Top module: `pblk_cmd_seq`

## Requirements
- R1: After reset the block is idle: busy_o=0, done_o=0, irq_o=0, mem_req_o=0, xfer_start_o=0, rtype_o=2'b10, err_o=8'h00, and every drive's track and sector registers read 0.
- R2: A start_i pulse while idle reads 7 bytes from the 7 consecutive addresses starting at pb_addr_i, lowest address first. Only one request is outstanding at a time. mem_req_o and mem_addr_o hold until mem_valid_i returns the byte. The bytes are: 0 channel word, 1 instruction, 2 record count, 3 track, 4 sector, 5 buffer address low, 6 buffer address high.
- R3: The drive number is instruction bits 5:4 and its ready state is rdy_i[drive]. A drive that is not ready is checked first. It ends the command with rtype_o=2'b00 and err_o=8'h80, whatever else is wrong with the command.
- R4: The opcode is instruction bits 2:0. For every opcode except recalibrate (3), the command ends with rtype_o=2'b00 and err_o=8'h08 if any of these holds: sector is 0, sector is above 52, sector+count is above 53, or track is above 76. Track 76, sector 52 and sector+count=53 are all accepted.
- R5: A successful seek (1) loads the selected drive's track and sector registers from the block. A successful recalibrate (3) loads the sector and clears the track. Other drives' registers, and all registers on a failed command, are left unchanged.
- R6: Format (2), write (6) and write-deleted (7) on a drive with wp_i[drive]=1 end with rtype_o=2'b00 and err_o=8'h20, and no transfer starts. This check comes after the address check. Read is not affected by wp_i.
- R7: No-op (0), seek (1), recalibrate (3) and verify (5) that pass the checks complete without a transfer, with rtype_o=2'b10 and err_o=8'h00.
- R8: Read (4), write (6), write-deleted (7) and format (2) that pass the checks raise xfer_start_o for one cycle. xfer_op_o is 0 for read, 1 for write and write-deleted, and 2 for format. The block then waits for xfer_done_i and completes with rtype_o=2'b10 and err_o=8'h00.
- R9: During a transfer:
  - xfer_drive_o, xfer_track_o, xfer_sector_o and xfer_count_o carry the block's fields.
  - xfer_buf_o is {byte 6, byte 5}.
  - xfer_wide_o is channel word bit 3.
- R10: done_o is high for exactly one cycle, and the result outputs already hold the new values in that cycle. irq_o is set by every completion and stays set until irq_ack_i. If a set and an acknowledge fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a command (accepted while idle) |
| pb_addr_i | input | AW | Parameter block base address |
| rdy_i | input | NDRV | Per-drive ready |
| wp_i | input | NDRV | Per-drive write protect |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_valid_i | input | 1 | Read data valid, ends the request |
| mem_data_i | input | 8 | Read data byte |
| xfer_start_o | output | 1 | Transfer engine start pulse |
| xfer_op_o | output | 2 | 0 read, 1 write, 2 format |
| xfer_drive_o | output | 2 | Selected drive |
| xfer_wide_o | output | 1 | 16-bit data word request |
| xfer_count_o | output | 8 | Record count |
| xfer_track_o | output | 8 | Track |
| xfer_sector_o | output | 8 | First sector |
| xfer_buf_o | output | 16 | Buffer address |
| xfer_done_i | input | 1 | Transfer engine finished |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| irq_o | output | 1 | Interrupt flag |
| irq_ack_i | input | 1 | Clear interrupt flag |
| rtype_o | output | 2 | Result type: 00 error, 10 ok |
| err_o | output | 8 | Error byte |
| drv_track_o | output | NDRV*8 | Track registers, drive d at [8d+7:8d] |
| drv_sector_o | output | NDRV*8 | Sector registers, drive d at [8d+7:8d] |

## Verification
The bench builds the block with its defaults: four drives, a 16-bit address, a last sector of 52 and a last track of 76. With four drives, every value of the two drive-select bits maps to a real drive, so per-drive ready, write protect and register isolation can all be driven independently. With the production geometry limits, the bench probes the exact edges 52/53 and 76/77 and the sector-plus-count sum of 53 against 54. A 16-bit buffer address lets it tell the little-endian assembly apart from a byte swap.

// File: rtl/pblk_pkg.sv
package pblk_pkg;
  localparam int PB_BYTES = 7;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SEEK   = 3'd1,
    OP_FMT    = 3'd2,
    OP_RECAL  = 3'd3,
    OP_READ   = 3'd4,
    OP_VERIFY = 3'd5,
    OP_WRITE  = 3'd6,
    OP_WRDEL  = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    XF_READ   = 2'd0,
    XF_WRITE  = 2'd1,
    XF_FORMAT = 2'd2
  } xfer_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EVAL, S_XFER, S_REPORT
  } seq_state_e;

  localparam logic [1:0] RT_ERROR = 2'b00;
  localparam logic [1:0] RT_OK    = 2'b10;

  localparam logic [7:0] ERR_NONE      = 8'h00;
  localparam logic [7:0] ERR_NOT_READY = 8'h80;
  localparam logic [7:0] ERR_ADDR      = 8'h08;
  localparam logic [7:0] ERR_WPROT     = 8'h20;

  typedef struct packed {
    logic [7:0]  chan;
    logic [7:0]  instr;
    logic [7:0]  count;
    logic [7:0]  track;
    logic [7:0]  sector;
    logic [15:0] buf_addr;
  } pblk_t;
endpackage

// File: rtl/pblk_fetch.sv
module pblk_fetch
  import pblk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [7:0]    mem_data_i,
  output logic          done_o,
  output pblk_t         blk_o
);
  localparam int IW = $clog2(PB_BYTES);
  localparam logic [IW-1:0] LAST_IDX = IW'(PB_BYTES - 1);

  logic          active_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic          done_q;
  logic [7:0]    byte_q [PB_BYTES];

  logic take;
  assign take = active_q && mem_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        base_q   <= base_i;
      end else if (take) begin
        if (idx_q == LAST_IDX) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < PB_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               byte_q[b] <= '0;
      else if (take && idx_q == IW'(b))          byte_q[b] <= mem_data_i;
    end
  end

  assign mem_req_o  = active_q;
  assign mem_addr_o = base_q + AW'(idx_q);
  assign done_o     = done_q;

  assign blk_o.chan     = byte_q[0];
  assign blk_o.instr    = byte_q[1];
  assign blk_o.count    = byte_q[2];
  assign blk_o.track    = byte_q[3];
  assign blk_o.sector   = byte_q[4];
  assign blk_o.buf_addr = {byte_q[6], byte_q[5]};
endmodule

// File: rtl/pblk_check.sv
module pblk_check
  import pblk_pkg::*;
#(
  parameter int NDRV    = 4,
  parameter int MAX_SEC = 52,
  parameter int MAX_TRK = 76
) (
  input  pblk_t           blk_i,
  input  logic [NDRV-1:0] rdy_i,
  input  logic [NDRV-1:0] wp_i,
  output logic [7:0]      err_o
);
  logic [1:0] drv;
  opcode_e    op;
  logic       drv_rdy, drv_wp, addr_bad, needs_wr;
  logic [8:0] span;

  assign drv  = blk_i.instr[5:4];
  assign op   = opcode_e'(blk_i.instr[2:0]);
  assign span = {1'b0, blk_i.sector} + {1'b0, blk_i.count};

  always_comb begin
    drv_rdy = 1'b0;
    drv_wp  = 1'b0;
    for (int d = 0; d < NDRV; d++) begin
      if (drv == 2'(d)) begin
        drv_rdy = rdy_i[d];
        drv_wp  = wp_i[d];
      end
    end
  end

  assign addr_bad = (op != OP_RECAL) &&
                    ((blk_i.sector == 8'd0) ||
                     (blk_i.sector > 8'(MAX_SEC)) ||
                     (span > 9'(MAX_SEC + 1)) ||
                     (blk_i.track > 8'(MAX_TRK)));

  assign needs_wr = (op == OP_FMT) || (op == OP_WRITE) || (op == OP_WRDEL);

  // fixed priority: ready, address, write protect
  always_comb begin
    if (!drv_rdy)              err_o = ERR_NOT_READY;
    else if (addr_bad)         err_o = ERR_ADDR;
    else if (needs_wr && drv_wp) err_o = ERR_WPROT;
    else                       err_o = ERR_NONE;
  end
endmodule

// File: rtl/drive_pos_regs.sv
module drive_pos_regs #(
  parameter int NDRV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [1:0]        drv_i,
  input  logic [7:0]        track_i,
  input  logic [7:0]        sector_i,
  output logic [NDRV*8-1:0] track_o,
  output logic [NDRV*8-1:0] sector_o
);
  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    logic [7:0] trk_q, sec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        trk_q <= '0;
        sec_q <= '0;
      end else if (upd_i && drv_i == 2'(d)) begin
        trk_q <= track_i;
        sec_q <= sector_i;
      end
    end
    assign track_o[d*8 +: 8]  = trk_q;
    assign sector_o[d*8 +: 8] = sec_q;
  end
endmodule

// File: rtl/pblk_cmd_seq.sv
module pblk_cmd_seq
  import pblk_pkg::*;
#(
  parameter int AW      = 16,
  parameter int NDRV    = 4,
  parameter int MAX_SEC = 52,
  parameter int MAX_TRK = 76
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     pb_addr_i,
  input  logic [NDRV-1:0]   rdy_i,
  input  logic [NDRV-1:0]   wp_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic              xfer_start_o,
  output logic [1:0]        xfer_op_o,
  output logic [1:0]        xfer_drive_o,
  output logic              xfer_wide_o,
  output logic [7:0]        xfer_count_o,
  output logic [7:0]        xfer_track_o,
  output logic [7:0]        xfer_sector_o,
  output logic [15:0]       xfer_buf_o,
  input  logic              xfer_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  input  logic              irq_ack_i,
  output logic [1:0]        rtype_o,
  output logic [7:0]        err_o,
  output logic [NDRV*8-1:0] drv_track_o,
  output logic [NDRV*8-1:0] drv_sector_o
);
  seq_state_e state_q, state_d;
  pblk_t      blk;
  logic       fetch_done;
  logic [7:0] chk_err;
  opcode_e    op;
  logic       is_xfer, is_pos, eval_ok;
  logic       finish, fin_error;
  logic [1:0] rtype_q;
  logic [7:0] err_q;
  logic       irq_q;
  logic       pos_upd;

  logic unused_fields;
  assign unused_fields = ^{blk.chan[7:4], blk.chan[2:0], blk.instr[7:6], blk.instr[3]};

  pblk_fetch #(.AW(AW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (state_q == S_IDLE && start_i),
    .base_i      (pb_addr_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_data_i  (mem_data_i),
    .done_o      (fetch_done),
    .blk_o       (blk)
  );

  pblk_check #(.NDRV(NDRV), .MAX_SEC(MAX_SEC), .MAX_TRK(MAX_TRK)) u_check (
    .blk_i (blk),
    .rdy_i (rdy_i),
    .wp_i  (wp_i),
    .err_o (chk_err)
  );

  assign op      = opcode_e'(blk.instr[2:0]);
  assign is_xfer = (op == OP_READ) || (op == OP_WRITE) || (op == OP_WRDEL) || (op == OP_FMT);
  assign is_pos  = (op == OP_SEEK) || (op == OP_RECAL);
  assign eval_ok = (state_q == S_EVAL) && (chk_err == ERR_NONE);
  assign pos_upd = eval_ok && is_pos;

  drive_pos_regs #(.NDRV(NDRV)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (pos_upd),
    .drv_i    (blk.instr[5:4]),
    .track_i  ((op == OP_RECAL) ? 8'd0 : blk.track),
    .sector_i (blk.sector),
    .track_o  (drv_track_o),
    .sector_o (drv_sector_o)
  );

  always_comb begin
    state_d   = state_q;
    finish    = 1'b0;
    fin_error = 1'b0;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_FETCH;
      S_FETCH:  if (fetch_done) state_d = S_EVAL;
      S_EVAL: begin
        if (chk_err != ERR_NONE) begin
          finish    = 1'b1;
          fin_error = 1'b1;
          state_d   = S_REPORT;
        end else if (is_xfer) begin
          state_d = S_XFER;
        end else begin
          finish  = 1'b1;
          state_d = S_REPORT;
        end
      end
      S_XFER: if (xfer_done_i) begin
        finish  = 1'b1;
        state_d = S_REPORT;
      end
      S_REPORT: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rtype_q <= RT_OK;
      err_q   <= ERR_NONE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (finish) begin
        rtype_q <= fin_error ? RT_ERROR : RT_OK;
        err_q   <= fin_error ? chk_err : ERR_NONE;
      end
      if (finish)         irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (op)
      OP_READ:  xfer_op_o = XF_READ;
      OP_FMT:   xfer_op_o = XF_FORMAT;
      default:  xfer_op_o = XF_WRITE;
    endcase
  end

  assign xfer_start_o  = eval_ok && is_xfer;
  assign xfer_drive_o  = blk.instr[5:4];
  assign xfer_wide_o   = blk.chan[3];
  assign xfer_count_o  = blk.count;
  assign xfer_track_o  = blk.track;
  assign xfer_sector_o = blk.sector;
  assign xfer_buf_o    = blk.buf_addr;

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_REPORT);
  assign irq_o   = irq_q;
  assign rtype_o = rtype_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pblk_cmd_seq_chk.sv
module pblk_cmd_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          xfer_start_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          irq_o,
  input logic [1:0]    rtype_o,
  input logic [7:0]    err_o
);
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  // R2
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R8
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, xfer_start_o, done_o}));

  // R8
  xfer_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> irq_o);

  // R7
  ok_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && rtype_o == 2'b10 |-> err_o == 8'h00);

  // R3
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && rtype_o == 2'b00 |-> $countones(err_o) == 1);
endmodule

bind pblk_cmd_seq pblk_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_valid_i  (mem_valid_i),
  .xfer_start_o (xfer_start_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .irq_o        (irq_o),
  .rtype_o      (rtype_o),
  .err_o        (err_o)
);

// File: tb/sim_pblk_cmd_seq.sv
module sim_pblk_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NDRV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            start = 1'b0;
  logic [AW-1:0]   pb_addr = '0;
  logic [NDRV-1:0] rdy = 4'hF;
  logic [NDRV-1:0] wp = 4'h0;
  logic            mem_req, mem_valid;
  logic [AW-1:0]   mem_addr;
  logic [7:0]      mem_data;
  logic            xfer_start, xfer_wide, xfer_done;
  logic [1:0]      xfer_op, xfer_drive;
  logic [7:0]      xfer_count, xfer_track, xfer_sector;
  logic [15:0]     xfer_buf;
  logic            busy, done, irq, irq_ack;
  logic [1:0]      rtype;
  logic [7:0]      err;
  logic [NDRV*8-1:0] drv_trk, drv_sec;

  pblk_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pb_addr_i(pb_addr),
    .rdy_i(rdy), .wp_i(wp),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .xfer_start_o(xfer_start), .xfer_op_o(xfer_op), .xfer_drive_o(xfer_drive),
    .xfer_wide_o(xfer_wide), .xfer_count_o(xfer_count), .xfer_track_o(xfer_track),
    .xfer_sector_o(xfer_sector), .xfer_buf_o(xfer_buf), .xfer_done_i(xfer_done),
    .busy_o(busy), .done_o(done), .irq_o(irq), .irq_ack_i(irq_ack),
    .rtype_o(rtype), .err_o(err), .drv_track_o(drv_trk), .drv_sector_o(drv_sec)
  );

  // memory model: one byte per request, valid one cycle after request
  logic [7:0]  mem [256];
  logic [15:0] req_log [16];
  int          req_n = 0;
  initial begin
    mem_valid = 1'b0;
    mem_data  = '0;
    xfer_done = 1'b0;
    irq_ack   = 1'b0;
  end
  always @(posedge clk) begin
    if (mem_req && !mem_valid) begin
      if (req_n < 16) req_log[req_n] <= mem_addr;
      req_n <= req_n + 1;
    end
    mem_valid <= mem_req && !mem_valid;
    mem_data  <= mem[mem_addr[7:0]];
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // captured results of last command
  bit         saw_xfer;
  logic [1:0] c_op, c_drv;
  logic       c_wide;
  logic [7:0] c_cnt, c_trk, c_sec;
  logic [15:0] c_buf;
  logic [1:0] r_type;
  logic [7:0] r_err;
  logic       r_irq;
  logic       r_done_low;

  task automatic run_cmd(input logic [7:0] base, input logic [7:0] chan, input logic [7:0] instr,
                         input logic [7:0] cnt, input logic [7:0] trk, input logic [7:0] sec,
                         input logic [15:0] bufa);
    int cd;
    bit got;
    mem[base]   = chan;  mem[base+1] = instr; mem[base+2] = cnt;
    mem[base+3] = trk;   mem[base+4] = sec;
    mem[base+5] = bufa[7:0]; mem[base+6] = bufa[15:8];
    @(negedge clk);
    req_n   = 0;
    pb_addr = {8'h00, base};
    start   = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    cd       = -1;
    saw_xfer = 0;
    got      = 0;
    for (int cyc = 0; cyc < 1000 && !got; cyc++) begin
      xfer_done = 1'b0;
      if (cd == 0) xfer_done = 1'b1;
      if (cd >= 0) cd--;
      if (xfer_start) begin
        saw_xfer = 1;
        c_op = xfer_op; c_drv = xfer_drive; c_wide = xfer_wide;
        c_cnt = xfer_count; c_trk = xfer_track; c_sec = xfer_sector; c_buf = xfer_buf;
        cd = 2;
      end
      if (done) begin
        got = 1;
        r_type = rtype; r_err = err; r_irq = irq;
      end
      @(negedge clk);
    end
    xfer_done  = 1'b0;
    r_done_low = !done;
    if (!got) chk("R10 command timeout", 32'd0, 32'd1);
  endtask

  task automatic expect_result(input string tag, input logic [1:0] t, input logic [7:0] e);
    chk({tag, " rtype"}, 32'(r_type), 32'(t));
    chk({tag, " err"},   32'(r_err),  32'(e));
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 memreq", 32'(mem_req), 0);
    chk("R1 rtype", 32'(rtype), 32'h2);
    chk("R1 err", 32'(err), 0);
    chk("R1 track regs", drv_trk, 0);
    chk("R1 sector regs", drv_sec, 0);
  endtask

  task automatic t_seek;
    run_cmd(8'h30, 8'h00, 8'h21, 8'd1, 8'd40, 8'd17, 16'h0000);
    for (int i = 0; i < 7; i++) chk("R2 fetch address", 32'(req_log[i]), 32'h30 + i);
    chk("R2 request count", req_n, 7);
    expect_result("R7 seek", 2'b10, 8'h00);
    chk("R7 seek no xfer", 32'(saw_xfer), 0);
    chk("R5 seek track", 32'(drv_trk[16 +: 8]), 40);
    chk("R5 seek sector", 32'(drv_sec[16 +: 8]), 17);
    chk("R5 other drive", 32'(drv_trk[0 +: 8]), 0);
    chk("R10 done width", 32'(r_done_low), 1);
    chk("R10 irq set", 32'(r_irq), 1);
  endtask

  task automatic t_recal;
    run_cmd(8'h40, 8'h00, 8'h11, 8'd1, 8'd10, 8'd5, 16'h0);
    chk("R5 seek drive1 track", 32'(drv_trk[8 +: 8]), 10);
    // recalibrate with out-of-range fields: no address check
    run_cmd(8'h40, 8'h00, 8'h13, 8'd200, 8'd99, 8'd0, 16'h0);
    expect_result("R4 recal bypass", 2'b10, 8'h00);
    chk("R5 recal track", 32'(drv_trk[8 +: 8]), 0);
    chk("R5 recal sector", 32'(drv_sec[8 +: 8]), 0);
  endtask

  task automatic t_not_ready;
    rdy = 4'b1011;
    run_cmd(8'h50, 8'h00, 8'h21, 8'd1, 8'd90, 8'd0, 16'h0);
    expect_result("R3 not ready precedence", 2'b00, 8'h80);
    chk("R3 irq", 32'(r_irq), 1);
    chk("R5 failed seek keeps track", 32'(drv_trk[16 +: 8]), 40);
    chk("R5 failed seek keeps sector", 32'(drv_sec[16 +: 8]), 17);
    rdy = 4'hF;
  endtask

  task automatic t_addr;
    run_cmd(8'h60, 8'h00, 8'h00, 8'd1, 8'd3, 8'd0, 16'h0);
    expect_result("R4 sector zero", 2'b00, 8'h08);
    run_cmd(8'h60, 8'h00, 8'h00, 8'd1, 8'd3, 8'd53, 16'h0);
    expect_result("R4 sector 53", 2'b00, 8'h08);
    run_cmd(8'h60, 8'h00, 8'h00, 8'd4, 8'd3, 8'd50, 16'h0);
    expect_result("R4 span 54", 2'b00, 8'h08);
    run_cmd(8'h60, 8'h00, 8'h00, 8'd1, 8'd77, 8'd1, 16'h0);
    expect_result("R4 track 77", 2'b00, 8'h08);
    run_cmd(8'h60, 8'h00, 8'h00, 8'd1, 8'd76, 8'd52, 16'h0);
    expect_result("R4 upper edge ok", 2'b10, 8'h00);
    run_cmd(8'h60, 8'h00, 8'h05, 8'd52, 8'd0, 8'd1, 16'h0);
    expect_result("R7 verify span 53", 2'b10, 8'h00);
    chk("R7 verify no xfer", 32'(saw_xfer), 0);
    run_cmd(8'h60, 8'h00, 8'h01, 8'd1, 8'd77, 8'd1, 16'h0);
    expect_result("R4 seek bad track", 2'b00, 8'h08);
    chk("R5 drive0 unchanged", 32'(drv_trk[0 +: 8]), 0);
  endtask

  task automatic t_wp;
    wp = 4'b0010;
    run_cmd(8'h70, 8'h00, 8'h16, 8'd1, 8'd5, 8'd5, 16'h0);
    expect_result("R6 write protected", 2'b00, 8'h20);
    chk("R6 no xfer", 32'(saw_xfer), 0);
    run_cmd(8'h70, 8'h00, 8'h12, 8'd1, 8'd5, 8'd1, 16'h0);
    expect_result("R6 format protected", 2'b00, 8'h20);
    run_cmd(8'h70, 8'h00, 8'h17, 8'd1, 8'd5, 8'd5, 16'h0);
    expect_result("R6 wrdel protected", 2'b00, 8'h20);
    run_cmd(8'h70, 8'h00, 8'h16, 8'd1, 8'd80, 8'd5, 16'h0);
    expect_result("R6 address before wp", 2'b00, 8'h08);
    run_cmd(8'h70, 8'h00, 8'h14, 8'd1, 8'd5, 8'd5, 16'h0);
    expect_result("R6 read ignores wp", 2'b10, 8'h00);
    chk("R6 read xfer started", 32'(saw_xfer), 1);
    rdy = 4'b1101;
    run_cmd(8'h70, 8'h00, 8'h16, 8'd1, 8'd5, 8'd5, 16'h0);
    expect_result("R3 ready before wp", 2'b00, 8'h80);
    rdy = 4'hF;
    wp  = 4'h0;
  endtask

  task automatic t_xfer;
    run_cmd(8'h80, 8'h08, 8'h36, 8'd3, 8'd12, 8'd7, 16'hA55A);
    chk("R8 write xfer", 32'(saw_xfer), 1);
    chk("R8 write op", 32'(c_op), 1);
    chk("R9 drive", 32'(c_drv), 3);
    chk("R9 track", 32'(c_trk), 12);
    chk("R9 sector", 32'(c_sec), 7);
    chk("R9 count", 32'(c_cnt), 3);
    chk("R9 buffer little endian", 32'(c_buf), 32'hA55A);
    chk("R9 wide", 32'(c_wide), 1);
    expect_result("R8 write done", 2'b10, 8'h00);
    run_cmd(8'h80, 8'h00, 8'h37, 8'd1, 8'd2, 8'd2, 16'h1234);
    chk("R8 wrdel as write", 32'(c_op), 1);
    chk("R9 wide clear", 32'(c_wide), 0);
    run_cmd(8'h80, 8'h00, 8'h02, 8'd1, 8'd9, 8'd1, 16'h0);
    chk("R8 format op", 32'(c_op), 2);
    run_cmd(8'h80, 8'h00, 8'h04, 8'd2, 8'd9, 8'd4, 16'h00FF);
    chk("R8 read op", 32'(c_op), 0);
    expect_result("R8 read done", 2'b10, 8'h00);
    chk("R10 done width xfer", 32'(r_done_low), 1);
  endtask

  task automatic t_irq;
    chk("R10 irq held", 32'(irq), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 irq cleared", 32'(irq), 0);
    run_cmd(8'h90, 8'h00, 8'h00, 8'd1, 8'd1, 8'd1, 16'h0);
    chk("R10 irq set again", 32'(irq), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seek();
    t_recal();
    t_not_ready();
    t_addr();
    t_wp();
    t_xfer();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule